// File: doc/BRIEF.md
# Tic-Tac-Toe Game Engine

This block holds the game state for two players sharing a 3x3 board. A selection cursor moves one cell per request with four direction inputs. A place input writes the mark of the player whose turn it is into the cell under the cursor. Player 1 plays X and player 2 plays O, and the turn passes to the other player after every accepted mark.

Each time a mark is written, the block checks every row, every column and both diagonals. If one of them holds three equal marks it reports a win for that player. If the board is full and no line exists it reports a draw. Once a result is posted the game is frozen until reset.

Button inputs are expected to arrive already debounced. Each of them is taken as a one-cycle request: every clock edge that sees an input high counts as one press. Outputs carry the packed board, the cursor, the turn and the result, for a display or another controller to use.

Top module: `ttt_engine`

## Requirements
- R1: After reset every cell is empty, the cursor is at row 0 column 0, turn_o is 0 (player 1, X) and result_o is 00 (game in progress).
- R2: A cell is coded on 2 bits: 00 empty, 01 X, 10 O. Cell (row, col) sits at board_o bits [2k+1:2k] with k = row*3 + col. An accepted place writes the current player's code into the cursor cell at that clock edge, and no other cell changes.
- R3: turn_o is 0 when X is to move and 1 when O is to move. It toggles at the edge that accepts a mark.
- R4: Each edge with an input high moves the cursor one step. up_i decrements the row, down_i increments it, left_i decrements the column and right_i increments it. If up_i and down_i are high together the row does not change, and the same holds for the columns with left_i and right_i.
- R5: A place request on a non-empty cell leaves the board and turn_o unchanged.
- R6: The cursor saturates at the grid edges: row and column stay within 0..2 and never wrap.
- R7: result_o becomes 01 when X completes a row, column or diagonal and 10 when O does. It is updated at the same edge that writes the completing mark.
- R8: result_o becomes 11 (draw) when the ninth mark fills the board without a line. A line completed by the ninth mark is reported as a win, not a draw.
- R9: While result_o is non-zero, all direction and place inputs are ignored: the board, cursor, turn and result hold until reset.
- R10: When place_i and a direction input are high in the same cycle, the mark goes to the cursor cell as it was before that edge, and the cursor moves as well.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| up_i | input | 1 | Move cursor one row up |
| down_i | input | 1 | Move cursor one row down |
| left_i | input | 1 | Move cursor one column left |
| right_i | input | 1 | Move cursor one column right |
| place_i | input | 1 | Place current player's mark at cursor |
| board_o | output | 18 | Packed cell codes, 2 bits per cell |
| cur_row_o | output | 2 | Cursor row |
| cur_col_o | output | 2 | Cursor column |
| turn_o | output | 1 | 0: X to move, 1: O to move |
| result_o | output | 2 | 00 playing, 01 X wins, 10 O wins, 11 draw |

## Verification
The bench presses place on an occupied cell. A design that wrote over the cell or passed the turn would show a changed board or a flipped turn_o. It drives the cursor into every edge, presses opposing directions together, and pairs a move with a place. This catches a wrapping cursor, an unbalanced up/down priority, and a place that lands on the cell the cursor moves to. It plays a full-board draw and a game won by the ninth mark, which tell apart a design that checks fullness before lines. After each finished game it keeps pressing inputs, to catch an engine that still moves or writes once a result is posted.

// File: rtl/ttt_pkg.sv
package ttt_pkg;
  typedef enum logic [1:0] {
    CELL_EMPTY = 2'b00,
    CELL_X     = 2'b01,
    CELL_O     = 2'b10
  } cell_e;

  typedef enum logic [1:0] {
    RES_PLAY  = 2'b00,
    RES_X_WIN = 2'b01,
    RES_O_WIN = 2'b10,
    RES_DRAW  = 2'b11
  } result_e;
endpackage

// File: rtl/ttt_axis.sv
// One saturating cursor coordinate.
module ttt_axis #(
  parameter int N  = 3,
  parameter int PW = $clog2(N)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          dec_i,
  input  logic          inc_i,
  output logic [PW-1:0] pos_o
);
  localparam logic [PW-1:0] MAX_POS = PW'(N - 1);

  logic [PW-1:0] pos_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pos_q <= '0;
    end else if (en_i && dec_i && !inc_i && pos_q != '0) begin
      pos_q <= pos_q - 1'b1;
    end else if (en_i && inc_i && !dec_i && pos_q != MAX_POS) begin
      pos_q <= pos_q + 1'b1;
    end
  end

  assign pos_o = pos_q;
endmodule

// File: rtl/ttt_board.sv
// Cell storage; exposes next-state so the judge sees the mark being written.
module ttt_board
  import ttt_pkg::*;
#(
  parameter int N     = 3,
  parameter int PW    = $clog2(N),
  parameter int CELLS = N * N,
  parameter int IW    = $clog2(CELLS)
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        we_i,
  input  logic [PW-1:0]               row_i,
  input  logic [PW-1:0]               col_i,
  input  cell_e                       mark_i,
  output logic [CELLS-1:0][1:0]       cells_o,
  output logic [CELLS-1:0][1:0]       cells_nxt_o,
  output logic                        sel_empty_o
);
  logic [CELLS-1:0][1:0] cells_q;
  logic [IW-1:0]         idx;

  assign idx = IW'(row_i) * IW'(N) + IW'(col_i);

  for (genvar k = 0; k < CELLS; k++) begin : g_cell
    assign cells_nxt_o[k] = (we_i && idx == IW'(k)) ? mark_i : cells_q[k];
  end

  always_comb begin
    sel_empty_o = 1'b0;
    for (int k = 0; k < CELLS; k++) begin
      if (idx == IW'(k)) sel_empty_o = (cells_q[k] == CELL_EMPTY);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cells_q <= '0;
    else         cells_q <= cells_nxt_o;
  end

  assign cells_o = cells_q;
endmodule

// File: rtl/ttt_judge.sv
// Combinational line and fullness detection.
module ttt_judge
  import ttt_pkg::*;
#(
  parameter int N     = 3,
  parameter int CELLS = N * N
) (
  input  logic [CELLS-1:0][1:0] cells_i,
  output logic                  x_line_o,
  output logic                  o_line_o,
  output logic                  full_o
);
  logic [N-1:0] row_x, row_o, col_x, col_o;
  logic         dia_x, dia_o, anti_x, anti_o;

  for (genvar g = 0; g < N; g++) begin : g_line
    logic rx, ro, cx, co;
    always_comb begin
      rx = 1'b1; ro = 1'b1; cx = 1'b1; co = 1'b1;
      for (int k = 0; k < N; k++) begin
        rx &= (cells_i[g*N + k] == CELL_X);
        ro &= (cells_i[g*N + k] == CELL_O);
        cx &= (cells_i[k*N + g] == CELL_X);
        co &= (cells_i[k*N + g] == CELL_O);
      end
    end
    assign row_x[g] = rx;
    assign row_o[g] = ro;
    assign col_x[g] = cx;
    assign col_o[g] = co;
  end

  always_comb begin
    dia_x = 1'b1; dia_o = 1'b1; anti_x = 1'b1; anti_o = 1'b1;
    for (int g = 0; g < N; g++) begin
      dia_x  &= (cells_i[g*N + g] == CELL_X);
      dia_o  &= (cells_i[g*N + g] == CELL_O);
      anti_x &= (cells_i[g*N + (N-1-g)] == CELL_X);
      anti_o &= (cells_i[g*N + (N-1-g)] == CELL_O);
    end
  end

  always_comb begin
    full_o = 1'b1;
    for (int k = 0; k < CELLS; k++) full_o &= (cells_i[k] != CELL_EMPTY);
  end

  assign x_line_o = (|row_x) | (|col_x) | dia_x | anti_x;
  assign o_line_o = (|row_o) | (|col_o) | dia_o | anti_o;
endmodule

// File: rtl/ttt_engine.sv
module ttt_engine
  import ttt_pkg::*;
#(
  parameter int N = 3
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   up_i,
  input  logic                   down_i,
  input  logic                   left_i,
  input  logic                   right_i,
  input  logic                   place_i,
  output logic [2*N*N-1:0]       board_o,
  output logic [$clog2(N)-1:0]   cur_row_o,
  output logic [$clog2(N)-1:0]   cur_col_o,
  output logic                   turn_o,
  output logic [1:0]             result_o
);
  localparam int CELLS = N * N;
  localparam int PW    = $clog2(N);

  logic                  playing, accept, sel_empty;
  logic                  x_line, o_line, full;
  logic                  turn_q;
  result_e               result_q;
  cell_e                 mark;
  logic [PW-1:0]         row, col;
  logic [CELLS-1:0][1:0] cells, cells_nxt;

  assign playing = (result_q == RES_PLAY);
  assign accept  = playing && place_i && sel_empty;
  assign mark    = turn_q ? CELL_O : CELL_X;

  ttt_axis #(.N(N), .PW(PW)) u_row (
    .clk_i (clk_i), .rst_ni (rst_ni), .en_i (playing),
    .dec_i (up_i),  .inc_i (down_i),  .pos_o (row)
  );

  ttt_axis #(.N(N), .PW(PW)) u_col (
    .clk_i (clk_i),  .rst_ni (rst_ni), .en_i (playing),
    .dec_i (left_i), .inc_i (right_i), .pos_o (col)
  );

  ttt_board #(.N(N), .PW(PW), .CELLS(CELLS)) u_board (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .we_i        (accept),
    .row_i       (row),
    .col_i       (col),
    .mark_i      (mark),
    .cells_o     (cells),
    .cells_nxt_o (cells_nxt),
    .sel_empty_o (sel_empty)
  );

  // Judge the board as it will be after this edge, so the result lands with the mark.
  ttt_judge #(.N(N), .CELLS(CELLS)) u_judge (
    .cells_i  (cells_nxt),
    .x_line_o (x_line),
    .o_line_o (o_line),
    .full_o   (full)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      turn_q   <= 1'b0;
      result_q <= RES_PLAY;
    end else if (accept) begin
      turn_q <= ~turn_q;
      if (x_line)      result_q <= RES_X_WIN;
      else if (o_line) result_q <= RES_O_WIN;
      else if (full)   result_q <= RES_DRAW;
    end
  end

  assign board_o   = cells;
  assign cur_row_o = row;
  assign cur_col_o = col;
  assign turn_o    = turn_q;
  assign result_o  = result_q;
endmodule

// File: rtl/ttt_engine_chk.sv
module ttt_engine_chk #(
  parameter int N = 3
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 up_i,
  input logic                 down_i,
  input logic                 left_i,
  input logic                 right_i,
  input logic                 place_i,
  input logic [2*N*N-1:0]     board_o,
  input logic [$clog2(N)-1:0] cur_row_o,
  input logic [$clog2(N)-1:0] cur_col_o,
  input logic                 turn_o,
  input logic [1:0]           result_o
);
  localparam int CELLS = N * N;

  logic sel_empty_c, full_c;

  always_comb begin
    sel_empty_c = 1'b0;
    full_c      = 1'b1;
    for (int k = 0; k < CELLS; k++) begin
      if (k == int'(cur_row_o) * N + int'(cur_col_o))
        sel_empty_c = (board_o[2*k +: 2] == 2'b00);
      full_c &= (board_o[2*k +: 2] != 2'b00);
    end
  end

  AST_PLACE_WRITES_CELL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (result_o == 2'b00 && place_i && sel_empty_c) |=> (board_o != $past(board_o))); // R2
  AST_SINGLE_BIT_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(board_o ^ $past(board_o)) <= 1); // R2
  AST_PLACE_FLIPS_TURN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (result_o == 2'b00 && place_i && sel_empty_c) |=> (turn_o != $past(turn_o))); // R3
  AST_ROW_IDLE_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (up_i == down_i) |=> $stable(cur_row_o)); // R4
  AST_COL_IDLE_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (left_i == right_i) |=> $stable(cur_col_o)); // R4
  AST_OCCUPIED_NO_EFFECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (place_i && !sel_empty_c) |=> ($stable(board_o) && $stable(turn_o))); // R5
  AST_CURSOR_IN_GRID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int'(cur_row_o) < N && int'(cur_col_o) < N)); // R6
  AST_DRAW_MEANS_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (result_o == 2'b11) |-> full_c); // R8
  AST_FROZEN_AFTER_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (result_o != 2'b00) |=> ($stable(board_o) && $stable(turn_o) && $stable(result_o)
                             && $stable(cur_row_o) && $stable(cur_col_o))); // R9
endmodule

bind ttt_engine ttt_engine_chk #(.N(N)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .up_i      (up_i),
  .down_i    (down_i),
  .left_i    (left_i),
  .right_i   (right_i),
  .place_i   (place_i),
  .board_o   (board_o),
  .cur_row_o (cur_row_o),
  .cur_col_o (cur_col_o),
  .turn_o    (turn_o),
  .result_o  (result_o)
);

// File: tb/ttt_engine_tb_top.sv
module ttt_engine_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int N          = 3;
  localparam int CELLS      = N * N;
  localparam int NVEC       = 18;

  // {up, down, left, right, place, row[1:0], col[1:0], turn, result[1:0]}
  localparam logic [11:0] VEC [NVEC] = '{
    12'b10000_00_00_0_00,  // up at top edge (R6)
    12'b00100_00_00_0_00,  // left at left edge (R6)
    12'b00001_00_00_1_00,  // X at (0,0) (R2 R3)
    12'b00010_00_01_1_00,  // right (R4)
    12'b00001_00_01_0_00,  // O at (0,1) (R2 R3)
    12'b00100_00_00_0_00,  // left (R4)
    12'b00001_00_00_0_00,  // place on X cell ignored (R5)
    12'b00010_00_01_0_00,
    12'b01000_01_01_0_00,  // down (R4)
    12'b00001_01_01_1_00,  // X at (1,1)
    12'b01000_10_01_1_00,
    12'b01000_10_01_1_00,  // down at bottom edge (R6)
    12'b00001_10_01_0_00,  // O at (2,1)
    12'b11000_10_01_0_00,  // up+down cancel (R4)
    12'b00010_10_10_0_00,
    12'b00001_10_10_1_01,  // X diagonal win (R7)
    12'b00100_10_10_1_01,  // frozen (R9)
    12'b10001_10_10_1_01   // frozen (R9)
  };

  logic clk, rst_ni;
  logic up, down, left, right, place;
  logic [2*CELLS-1:0] board;
  logic [1:0] cur_row, cur_col, result;
  logic turn;

  ttt_engine #(.N(N)) dut_i (
    .clk_i (clk), .rst_ni (rst_ni),
    .up_i (up), .down_i (down), .left_i (left), .right_i (right), .place_i (place),
    .board_o (board), .cur_row_o (cur_row), .cur_col_o (cur_col),
    .turn_o (turn), .result_o (result)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  int n_run, n_fail;
  logic done;
  int m_row, m_col, m_turn, m_res;
  logic [2*CELLS-1:0] m_board;

  task automatic check_int(input string req, input string what, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic check_state(input string req);
    check_int(req, "row", int'(cur_row), m_row);
    check_int(req, "col", int'(cur_col), m_col);
    check_int(req, "turn", int'(turn), m_turn);
    check_int(req, "result", int'(result), m_res);
    check_int(req, "board", int'(board), int'(m_board));
  endtask

  task automatic drive(input logic u, input logic d, input logic l, input logic r, input logic p);
    @(negedge clk);
    up = u; down = d; left = l; right = r; place = p;
    @(negedge clk);
    up = 0; down = 0; left = 0; right = 0; place = 0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_ni = 1'b0;
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;
    m_row = 0; m_col = 0; m_turn = 0; m_res = 0; m_board = '0;
  endtask

  task automatic move_to(input int r, input int c);
    while (m_row > r) begin drive(1, 0, 0, 0, 0); m_row--; check_state("R4 up"); end
    while (m_row < r) begin drive(0, 1, 0, 0, 0); m_row++; check_state("R4 down"); end
    while (m_col > c) begin drive(0, 0, 1, 0, 0); m_col--; check_state("R4 left"); end
    while (m_col < c) begin drive(0, 0, 0, 1, 0); m_col++; check_state("R4 right"); end
  endtask

  task automatic place_at(input int r, input int c, input int exp_res, input string req);
    move_to(r, c);
    drive(0, 0, 0, 0, 1);
    m_board[2*(r*N+c) +: 2] = (m_turn == 0) ? 2'b01 : 2'b10;
    m_turn = 1 - m_turn;
    m_res  = exp_res;
    check_state(req);
  endtask

  initial begin
    n_run = 0; n_fail = 0; done = 1'b0;
    up = 0; down = 0; left = 0; right = 0; place = 0;
    rst_ni = 1'b0;
    m_row = 0; m_col = 0; m_turn = 0; m_res = 0; m_board = '0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    check_state("R1 reset");

    // Vector walk: one game with edges, occupied cell and freeze
    for (int i = 0; i < NVEC; i++) begin
      drive(VEC[i][11], VEC[i][10], VEC[i][9], VEC[i][8], VEC[i][7]);
      check_int("R2 R3 R4 R5 R6 R7 R9 vec row", $sformatf("v%0d", i), int'(cur_row), int'(VEC[i][6:5]));
      check_int("R2 R3 R4 R5 R6 R7 R9 vec col", $sformatf("v%0d", i), int'(cur_col), int'(VEC[i][4:3]));
      check_int("R3 vec turn", $sformatf("v%0d", i), int'(turn), int'(VEC[i][2]));
      check_int("R7 R9 vec result", $sformatf("v%0d", i), int'(result), int'(VEC[i][1:0]));
    end
    m_board = '0;
    m_board[1:0] = 2'b01; m_board[3:2] = 2'b10; m_board[9:8] = 2'b01;
    m_board[15:14] = 2'b10; m_board[17:16] = 2'b01;
    check_int("R2 R5", "board after vectors", int'(board), int'(m_board));

    // R1: reset mid-state clears everything
    do_reset();
    @(negedge clk);
    check_state("R1 reset after win");

    // R10: place with a simultaneous move writes the old cell
    drive(0, 0, 0, 1, 1);
    m_board[1:0] = 2'b01; m_turn = 1; m_col = 1;
    check_state("R10 place+move");
    move_to(0, 2);
    drive(0, 0, 0, 1, 0);
    check_state("R6 right edge");

    // R7: O completes column 2
    do_reset();
    place_at(0, 0, 0, "R2 R3");
    place_at(0, 2, 0, "R2 R3");
    place_at(1, 1, 0, "R2 R3");
    place_at(1, 2, 0, "R2 R3");
    place_at(2, 0, 0, "R2 R3");
    place_at(2, 2, 2, "R7 O column");
    drive(1, 0, 1, 0, 1);
    check_state("R9 inputs after O win");
    drive(0, 0, 0, 0, 1);
    check_state("R9 place after O win");

    // R8: full board, no line
    do_reset();
    place_at(0, 0, 0, "R3");
    place_at(0, 1, 0, "R3");
    place_at(0, 2, 0, "R3");
    place_at(1, 1, 0, "R3");
    place_at(1, 0, 0, "R3");
    place_at(1, 2, 0, "R3");
    place_at(2, 1, 0, "R3");
    place_at(2, 0, 0, "R3");
    place_at(2, 2, 3, "R8 draw");
    drive(1, 0, 0, 0, 0);
    check_state("R9 after draw");

    // R8: ninth mark completes a line -> win, not draw
    do_reset();
    place_at(0, 0, 0, "R3");
    place_at(0, 1, 0, "R3");
    place_at(0, 2, 0, "R3");
    place_at(1, 0, 0, "R3");
    place_at(1, 1, 0, "R3");
    place_at(1, 2, 0, "R3");
    place_at(2, 1, 0, "R3");
    place_at(2, 0, 0, "R3");
    place_at(2, 2, 1, "R8 win on full board");

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule